// File: doc/BRIEF.md
# SDRAM Bank Open/Ready State Tracker

This block follows a decoded SDRAM command stream and keeps, for each of four banks, whether a row is open and whether the bank may be activated again. It can sit beside a memory controller as a protocol checker, or inside a behavioural memory model as its bank bookkeeping. Each clock it takes one command code, a bank address, the address bit that selects all-bank or auto-precharge behaviour (called `a10_i` here), and a burst-length selector.

It handles explicit precharge of one bank or of all banks, auto precharge at the end of a read or write burst, and two ways of cutting a burst short: a precharge, which also closes the bank, and a burst stop, which leaves the row open. After any close, a per-bank counter holds that bank not ready for a parameterised row-precharge time. Commands that break the bank rules raise a one-cycle illegal pulse and change no state.

Top module: `sdr_bank_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, every bank reads closed and ready, the burst flag is low and the illegal pulse is low.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, BURST STOP=5 (6 and 7 act as NOP); bank address value i maps to bit i of each per-bank output. An ACTIVE to a closed, ready bank sets that bank's open bit on the cycle after the command.
- R3: A PRECHARGE with `a10_i` high closes every open bank on the cycle after the command.
- R4: A PRECHARGE with `a10_i` low closes only the addressed bank; other banks keep their state, and a PRECHARGE to a bank that is already closed is legal and changes nothing.
- R5: When a bank closes, its ready bit is low for exactly TRP_CYC cycles (default 3) and then returns high; an open bank is always ready.
- R6: A legal READ or WRITE raises the burst flag on the next cycle and keeps it high for exactly the burst length; `bl_sel_i` values 0, 1, 2, 3 give 1, 2, 4, 8 beats.
- R7: A READ or WRITE with `a10_i` high closes its bank on the same edge that ends the burst flag, after which the R5 countdown runs.
- R8: A PRECHARGE that covers the bank of a running burst (by address or by `a10_i`) ends the burst and closes that bank on the next cycle.
- R9: A BURST STOP during a burst ends it on the next cycle and leaves every bank open, cancelling any pending auto precharge; with no burst running it has no effect.
- R10: An ACTIVE to an open or not-ready bank, a READ or WRITE to a closed bank, or a READ or WRITE while an auto-precharge burst runs, raises the illegal pulse for one cycle and changes no state.
- R11: A READ or WRITE without auto precharge issued during a plain burst restarts the burst with the new bank and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | All-bank select on precharge, auto-precharge request on read/write |
| bl_sel_i | input | 2 | Burst length select (1, 2, 4, 8) |
| bank_open_o | output | 4 | Per-bank row-open flag |
| bank_ready_o | output | 4 | Per-bank may-activate flag |
| burst_act_o | output | 1 | A read or write burst is in progress |
| illegal_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
Every output is registered, so the effect of a command sampled on one rising edge is due on the outputs after that same edge; the bench drives on the falling edge and compares on the following falling edge. The burst flag stays high for the burst length counted from that first cycle, an auto-precharge close lands on the edge where the flag drops, and ready then stays low for TRP_CYC further cycles. A behavioural reference model advances by the same one-edge rule and is compared against every output each cycle, so a result arriving a cycle early or late is reported.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } sdr_cmd_e;

  localparam int LEN_W = 4;

  function automatic logic [LEN_W-1:0] burst_beats(input logic [1:0] sel);
    logic [LEN_W-1:0] n;
    case (sel)
      2'd0:    n = 4'd1;
      2'd1:    n = 4'd2;
      2'd2:    n = 4'd4;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sbt_bank_slice.sv
module sbt_bank_slice #(
  parameter int TRP_CYC = 3,
  parameter int CW      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req_i,
  input  logic close_req_i,
  output logic open_o,
  output logic ready_o
);

  logic          open_q, open_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (close_req_i && open_q) begin
      open_d = 1'b0;
      cnt_d  = CW'(TRP_CYC);
    end else if (open_req_i) begin
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  assign open_o  = open_q;
  assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/sbt_burst_ctrl.sv
module sbt_burst_ctrl
  import sbt_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BA_W-1:0]  start_bank_i,
  input  logic             start_ap_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic             kill_i,
  output logic             act_o,
  output logic [BA_W-1:0]  bank_o,
  output logic             ap_o,
  output logic             ap_close_o
);

  logic             act_q, act_d;
  logic             ap_q, ap_d;
  logic [BA_W-1:0]  bank_q, bank_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             last_beat;

  assign last_beat = act_q && (rem_q == LEN_W'(1));

  always_comb begin
    act_d  = act_q;
    ap_d   = ap_q;
    bank_d = bank_q;
    rem_d  = rem_q;
    if (start_i) begin
      act_d  = 1'b1;
      ap_d   = start_ap_i;
      bank_d = start_bank_i;
      rem_d  = start_len_i;
    end else if (kill_i) begin
      act_d = 1'b0;
      ap_d  = 1'b0;
      rem_d = '0;
    end else if (act_q) begin
      if (last_beat) begin
        act_d = 1'b0;
        ap_d  = 1'b0;
        rem_d = '0;
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      rem_q  <= '0;
    end else begin
      act_q  <= act_d;
      ap_q   <= ap_d;
      bank_q <= bank_d;
      rem_q  <= rem_d;
    end
  end

  assign act_o      = act_q;
  assign bank_o     = bank_q;
  assign ap_o       = ap_q;
  assign ap_close_o = last_beat && ap_q && !kill_i && !start_i;

endmodule

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [1:0]           bl_sel_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic [NUM_BANKS-1:0] bank_ready_i,
  input  logic                 burst_act_i,
  input  logic [BA_W-1:0]      burst_bank_i,
  input  logic                 burst_ap_i,
  output logic [NUM_BANKS-1:0] act_vec_o,
  output logic [NUM_BANKS-1:0] pre_vec_o,
  output logic                 start_o,
  output logic [LEN_W-1:0]     start_len_o,
  output logic                 kill_o,
  output logic                 illegal_o
);

  sdr_cmd_e cmd;
  assign cmd         = sdr_cmd_e'(cmd_i);
  assign start_len_o = burst_beats(bl_sel_i);

  always_comb begin
    act_vec_o = '0;
    pre_vec_o = '0;
    start_o   = 1'b0;
    kill_o    = 1'b0;
    illegal_o = 1'b0;
    case (cmd)
      CMD_ACT: begin
        if (bank_open_i[ba_i] || !bank_ready_i[ba_i]) begin
          illegal_o = 1'b1;
        end else begin
          act_vec_o[ba_i] = 1'b1;
        end
      end
      CMD_RD, CMD_WR: begin
        if (!bank_open_i[ba_i] || (burst_act_i && burst_ap_i)) begin
          illegal_o = 1'b1;
        end else begin
          start_o = 1'b1;
        end
      end
      CMD_PRE: begin
        if (a10_i) begin
          pre_vec_o = '1;
        end else begin
          pre_vec_o[ba_i] = 1'b1;
        end
        kill_o = burst_act_i && (a10_i || (ba_i == burst_bank_i));
      end
      CMD_BST: begin
        kill_o = burst_act_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP_CYC   = 3,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int CW       = $clog2(TRP_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [1:0]           bl_sel_i,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [NUM_BANKS-1:0] bank_ready_o,
  output logic                 burst_act_o,
  output logic                 illegal_o
);

  logic [NUM_BANKS-1:0] act_vec, pre_vec, ap_vec, close_vec;
  logic                 start, kill, illegal_d, illegal_q;
  logic [LEN_W-1:0]     start_len;
  logic [BA_W-1:0]      burst_bank;
  logic                 burst_ap, ap_close;

  sbt_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_dec (
    .cmd_i        (cmd_i),
    .ba_i         (ba_i),
    .a10_i        (a10_i),
    .bl_sel_i     (bl_sel_i),
    .bank_open_i  (bank_open_o),
    .bank_ready_i (bank_ready_o),
    .burst_act_i  (burst_act_o),
    .burst_bank_i (burst_bank),
    .burst_ap_i   (burst_ap),
    .act_vec_o    (act_vec),
    .pre_vec_o    (pre_vec),
    .start_o      (start),
    .start_len_o  (start_len),
    .kill_o       (kill),
    .illegal_o    (illegal_d)
  );

  sbt_burst_ctrl #(.BA_W(BA_W)) u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .start_bank_i (ba_i),
    .start_ap_i   (a10_i),
    .start_len_i  (start_len),
    .kill_i       (kill),
    .act_o        (burst_act_o),
    .bank_o       (burst_bank),
    .ap_o         (burst_ap),
    .ap_close_o   (ap_close)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    assign ap_vec[gi]    = ap_close && (burst_bank == BA_W'(gi));
    assign close_vec[gi] = pre_vec[gi] || ap_vec[gi];

    sbt_bank_slice #(.TRP_CYC(TRP_CYC), .CW(CW)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .open_req_i  (act_vec[gi]),
      .close_req_i (close_vec[gi]),
      .open_o      (bank_open_o[gi]),
      .ready_o     (bank_ready_o[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= illegal_d;
    end
  end

  assign illegal_o = illegal_q;

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_i,
  input logic [BA_W-1:0]      ba_i,
  input logic                 a10_i,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic [NUM_BANKS-1:0] bank_ready_o,
  input logic                 burst_act_o,
  input logic                 illegal_o
);

  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ACT && !bank_open_o[ba_i] && bank_ready_o[ba_i])
      |=> bank_open_o[$past(ba_i)]);

  a_r3_all_close: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PRE && a10_i) |=> (bank_open_o == '0));

  a_r4_one_close: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PRE && !a10_i) |=> !bank_open_o[$past(ba_i)]);

  a_r8_pre_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PRE && a10_i && burst_act_o) |=> !burst_act_o);

  a_r9_stop_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_BST && burst_act_o)
      |=> (!burst_act_o && bank_open_o == $past(bank_open_o)));

  a_r10_act_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ACT && bank_open_o[ba_i]) |=> illegal_o);

  a_r10_access_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_open_o[ba_i]) |=> illegal_o);

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_chk
    a_r5_close_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_open_o[gi]) |-> !bank_ready_o[gi]);

    a_r5_open_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bank_open_o[gi] |-> bank_ready_o[gi]);
  end

endmodule

bind sdr_bank_tracker sbt_checker #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_i        (cmd_i),
  .ba_i         (ba_i),
  .a10_i        (a10_i),
  .bank_open_o  (bank_open_o),
  .bank_ready_o (bank_ready_o),
  .burst_act_o  (burst_act_o),
  .illegal_o    (illegal_o)
);

// File: tb/sdr_bank_tracker_tb.sv
`timescale 1ns/1ps
module sdr_bank_tracker_tb;

  localparam int NB  = 4;
  localparam int TRP = 3;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, BST = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cmd;
  logic [1:0]    ba;
  logic          a10;
  logic [1:0]    bl;
  logic [NB-1:0] open_w, ready_w;
  logic          bact_w, ill_w;

  always #2.5 clk = ~clk;

  sdr_bank_tracker #(.NUM_BANKS(NB), .TRP_CYC(TRP)) u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_i (cmd), .ba_i (ba), .a10_i (a10),
    .bl_sel_i (bl), .bank_open_o (open_w), .bank_ready_o (ready_w),
    .burst_act_o (bact_w), .illegal_o (ill_w)
  );

  int    total = 0, bad = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model state
  int m_open [NB];
  int m_cnt  [NB];
  int m_bact, m_bbank, m_rem, m_ap, m_ill;

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_cnt[i] = 0; end
    m_bact = 0; m_bbank = 0; m_rem = 0; m_ap = 0; m_ill = 0;
  endtask

  task automatic model_step(input int c, input int b, input int a, input int s);
    int shut [NB];
    int opn  [NB];
    int start, kill, len;
    start = 0; kill = 0; len = 1 << s; m_ill = 0;
    for (int i = 0; i < NB; i++) begin shut[i] = 0; opn[i] = 0; end
    if (c == 1) begin
      if (m_open[b] != 0 || m_cnt[b] != 0) m_ill = 1; else opn[b] = 1;
    end else if (c == 2 || c == 3) begin
      if (m_open[b] == 0 || (m_bact != 0 && m_ap != 0)) m_ill = 1; else start = 1;
    end else if (c == 4) begin
      for (int i = 0; i < NB; i++) if (a != 0 || i == b) shut[i] = 1;
      if (m_bact != 0 && (a != 0 || b == m_bbank)) kill = 1;
    end else if (c == 5) begin
      if (m_bact != 0) kill = 1;
    end
    // auto precharge at the final beat, unless the burst is cut or restarted
    if (m_bact != 0 && m_rem == 1 && m_ap != 0 && kill == 0 && start == 0)
      shut[m_bbank] = 1;
    if (start != 0) begin
      m_bact = 1; m_rem = len; m_bbank = b; m_ap = a;
    end else if (kill != 0) begin
      m_bact = 0; m_ap = 0;
    end else if (m_bact != 0) begin
      if (m_rem == 1) begin m_bact = 0; m_ap = 0; end
      else m_rem = m_rem - 1;
    end
    for (int i = 0; i < NB; i++) begin
      if (shut[i] != 0 && m_open[i] != 0) begin
        m_open[i] = 0; m_cnt[i] = TRP;
      end else begin
        if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
        if (opn[i] != 0) m_open[i] = 1;
      end
    end
  endtask

  task automatic compare();
    logic [NB-1:0] eo, er;
    for (int i = 0; i < NB; i++) begin
      eo[i] = (m_open[i] != 0);
      er[i] = (m_cnt[i] == 0);
    end
    total++;
    if (open_w !== eo || ready_w !== er || bact_w !== (m_bact != 0) ||
        ill_w !== (m_ill != 0)) begin
      bad++;
      $display("FAIL %s: open=%b/%b ready=%b/%b burst=%b/%b illegal=%b/%b (actual/expected)",
               tag, open_w, eo, ready_w, er, bact_w, (m_bact != 0), ill_w, (m_ill != 0));
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input bit a, input int s);
    cmd = c; ba = 2'(b); a10 = a; bl = 2'(s);
    @(posedge clk);
    model_step(int'(c), b, int'(a), s);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(NOP, 0, 1'b0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd = NOP; ba = 0; a10 = 0; bl = 0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();               // R1: state held in reset
    rst_n = 1'b1;
    idle(1);                             // R1: first cycle after release

    tag = "R2"; step(ACT, 0, 0, 0); step(ACT, 2, 0, 0); idle(1);
    tag = "R10"; step(ACT, 0, 0, 0); step(RD, 1, 0, 0); step(WR, 3, 1, 2); idle(1);

    tag = "R6";
    for (int s = 0; s < 4; s++) begin
      step(RD, 0, 0, s);
      idle(9);
    end
    step(WR, 2, 0, 3); idle(9);

    tag = "R11"; step(WR, 2, 0, 3); idle(2); step(RD, 0, 0, 1); idle(4);

    tag = "R9"; step(RD, 2, 0, 3); idle(1); step(BST, 0, 0, 0); idle(3);
    step(BST, 1, 0, 0); idle(1);
    step(WR, 0, 1, 2); idle(1); step(BST, 0, 0, 0); idle(6);

    tag = "R8"; step(RD, 0, 0, 3); idle(1); step(PRE, 0, 0, 0);
    tag = "R5"; step(ACT, 0, 0, 0); step(ACT, 0, 0, 0); idle(1); step(ACT, 0, 0, 0);
    tag = "R8"; step(WR, 2, 0, 3); idle(1); step(PRE, 1, 0, 0); idle(2);
    step(PRE, 0, 1, 0); idle(4);

    tag = "R4"; step(ACT, 1, 0, 0); step(ACT, 3, 0, 0); step(ACT, 0, 0, 0);
    step(PRE, 1, 0, 0); idle(1); step(PRE, 1, 0, 0); step(PRE, 2, 0, 0); idle(4);

    tag = "R3"; step(PRE, 2, 1, 0); idle(4);

    tag = "R7"; step(ACT, 3, 0, 0); step(ACT, 1, 0, 0);
    step(WR, 3, 1, 1); idle(6);
    step(ACT, 3, 0, 0); step(RD, 3, 1, 2);
    tag = "R10"; step(RD, 1, 0, 0); step(ACT, 3, 0, 0);
    tag = "R7"; idle(8);
    step(ACT, 3, 0, 0); step(RD, 3, 1, 0); idle(5);

    tag = "R2-R11 mixed";
    for (int k = 0; k < 800; k++) begin
      int c;
      c = int'($urandom_range(0, 9));
      if (c > 5) c = (c > 7) ? 1 : 0;
      step(3'(c), int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 3)));
    end

    finish_run();
  end

endmodule